// File: doc/BRIEF.md
# Buffered UART Transmitter with Selectable Interrupt

This block sends asynchronous serial characters on a single output line. A bus master writes a character into a one-entry holding register. At the next bit-clock boundary after the shift register becomes free, the held character moves into the frame shifter. This lets software queue the following character while the current one is still on the line. The line rests high. Each frame has a low start bit, then the data bits with the least significant bit first (eight, or seven when the short format is chosen), then an optional parity bit (even or odd), then one or two high stop bits.

Bit timing comes from a reloadable divider that emits a tick every `div_val+1` clocks. Each bit lasts sixteen of those ticks, and all shift-register loads and bit changes happen on those sixteen-tick boundaries. Two status outputs describe the state of the block. `tbe` reports that the holding register can take a new character. `tsc` reports that the shifter has finished its last frame and that nothing is waiting. A one-cycle interrupt pulse follows the rising edge of whichever of the two flags `cfg_irq_sel` selects.

Top module: `bufd_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `tbe` is 1, `tsc` is 1 and `tx_irq` is 0.
- R2: A frame is a 0 start bit, followed by data bits sent least significant bit first: 8 bits when `cfg_data8`=1, or bits 0..6 when `cfg_data8`=0, in which case bit 7 of the written value has no effect on the line. Every bit is held for 16*(`div_val`+1) clock cycles.
- R3: With `cfg_par_en`=1, a parity bit follows the data bits. With `cfg_par_odd`=0 the count of ones in data plus parity is even, and with `cfg_par_odd`=1 it is odd. With `cfg_par_en`=0, no parity bit is sent.
- R4: The frame ends with one stop bit of value 1, or two when `cfg_stop2`=1.
- R5: `tbe` reads 0 in the cycle after a write. It returns to 1 when the held character is loaded into the shifter, and that load is the cycle in which the start bit begins.
- R6: A character written while `tsc`=1 starts only on a bit-clock boundary. `tsc` falls between 2 and 16*(`div_val`+1)+1 clock cycles after the write is presented.
- R7: A character waiting at the end of a frame starts exactly when the last stop bit ends, so there is no idle gap on the line.
- R8: `tsc` rises exactly when the final stop bit ends and no character is waiting. It stays 0 between chained frames, and while it is 1 the line is high.
- R9: `tx_irq` is a single-cycle pulse in the cycle where the selected flag first reads 1. `cfg_irq_sel`=0 selects `tbe` and `cfg_irq_sel`=1 selects `tsc`.
- R10: A write made while `tbe`=0 replaces the waiting character, and the replaced value is never sent.
- R11: When every write waits for `tbe`=1, every written character is sent once, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_val | input | DIV_W | Tick divider: one baud tick every div_val+1 clocks |
| cfg_data8 | input | 1 | 1: full data width, 0: one bit shorter |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_irq_sel | input | 1 | Interrupt source: 0 buffer-empty, 1 shift-complete |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_MAX | Character to queue |
| txd | output | 1 | Serial output, high when idle |
| tbe | output | 1 | Holding register empty |
| tsc | output | 1 | Shifter finished and nothing waiting |
| tx_irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong bit counter or a wrong frame-length value shows up first on `txd`. A stop bit arrives early or late, and the next start edge moves away from its exact spacing, so the error is visible within one frame. A wrong flag update appears within a cycle or two. Either `tbe` stays low after the start bit, so the next queued write stalls and the line goes quiet, or `tsc` rises while a character is still waiting. A bad interrupt selection shows up at the end of the first burst as the wrong number of pulses: one per character versus one per burst.

// File: rtl/bufd_uart_tx_pkg.sv
package bufd_uart_tx_pkg;

   typedef enum logic {
      IRQ_ON_EMPTY = 1'b0,
      IRQ_ON_DONE  = 1'b1
   } irq_src_e;

   typedef struct packed {
      logic data8;
      logic par_en;
      logic par_odd;
      logic stop2;
   } frame_cfg_t;

endpackage

// File: rtl/bufd_uart_tx_baud.sv
module bufd_uart_tx_baud #(
   parameter int DIV_W      = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   output logic             bit_stb_o
);

   logic [DIV_W-1:0] div_q;
   logic             tick;

   always_ff @(posedge clk) begin
      if (!rst_n)
         div_q <= '0;
      else if (div_q == '0)
         div_q <= div_val;
      else
         div_q <= div_q - 1'b1;
   end

   assign tick = (div_q == '0);

   generate
      if (OVERSAMPLE == 1) begin : g_no_sub
         assign bit_stb_o = tick;
      end else begin : g_sub
         localparam int SUB_W = $clog2(OVERSAMPLE);
         localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
         logic [SUB_W-1:0] sub_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               sub_q <= '0;
            else if (tick) begin
               if (sub_q == SUB_LAST)
                  sub_q <= '0;
               else
                  sub_q <= sub_q + 1'b1;
            end
         end

         assign bit_stb_o = tick && (sub_q == SUB_LAST);
      end
   endgenerate

endmodule

// File: rtl/bufd_uart_tx_shifter.sv
module bufd_uart_tx_shifter
   import bufd_uart_tx_pkg::*;
#(
   parameter int DATA_MAX   = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_stb_i,
   input  logic                load_i,
   input  logic [DATA_MAX-1:0] data_i,
   input  frame_cfg_t          cfg_i,
   output logic                txd_o,
   output logic                slot_free_o,
   output logic                done_o
);

   localparam int FRAME_W = DATA_MAX + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] frame_q, frame_d;
   logic [CNT_W-1:0]   cnt_q, len_d;
   logic [DATA_MAX-1:0] masked;
   logic               busy, par_use, par_bit;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_use = cfg_i.par_en;
      end else begin : g_nopar
         assign par_use = 1'b0;
      end
   endgenerate

   always_comb begin
      masked = data_i;
      if (!cfg_i.data8)
         masked[DATA_MAX-1] = 1'b0;
   end

   assign par_bit = (^masked) ^ cfg_i.par_odd;

   always_comb begin
      int ndata;
      int nlen;
      ndata   = cfg_i.data8 ? DATA_MAX : DATA_MAX - 1;
      frame_d = '1;
      frame_d[0] = 1'b0;
      for (int i = 0; i < DATA_MAX; i++) begin
         if (i < ndata)
            frame_d[1 + i] = masked[i];
      end
      if (par_use)
         frame_d[1 + ndata] = par_bit;
      nlen  = 2 + ndata + (par_use ? 1 : 0) + (cfg_i.stop2 ? 1 : 0);
      len_d = CNT_W'(nlen);
   end

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '1;
         cnt_q   <= '0;
      end else if (load_i) begin
         frame_q <= frame_d;
         cnt_q   <= len_d;
      end else if (bit_stb_i && busy) begin
         frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
         cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign done_o      = bit_stb_i && busy && (cnt_q == CNT_W'(1));
   assign slot_free_o = !busy || (cnt_q == CNT_W'(1));
   assign txd_o       = busy ? frame_q[0] : 1'b1;

   assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(FRAME_W));

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_i) |-> !txd_o);

   assert_start_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |-> $past(bit_stb_i));

endmodule

// File: rtl/bufd_uart_tx_flags.sv
module bufd_uart_tx_flags
   import bufd_uart_tx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_i,
   input  logic     load_i,
   input  logic     done_i,
   input  irq_src_e irq_sel_i,
   output logic     tbe_o,
   output logic     tsc_o,
   output logic     irq_o
);

   logic tbe_d, tsc_d, irq_d;

   always_comb begin
      if (wr_i)
         tbe_d = 1'b0;
      else if (load_i)
         tbe_d = 1'b1;
      else
         tbe_d = tbe_o;

      if (load_i)
         tsc_d = 1'b0;
      else if (done_i)
         tsc_d = 1'b1;
      else
         tsc_d = tsc_o;

      if (irq_sel_i == IRQ_ON_DONE)
         irq_d = tsc_d & ~tsc_o;
      else
         irq_d = tbe_d & ~tbe_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbe_o <= 1'b1;
         tsc_o <= 1'b1;
         irq_o <= 1'b0;
      end else begin
         tbe_o <= tbe_d;
         tsc_o <= tsc_d;
         irq_o <= irq_d;
      end
   end

   assert_tbe_clear_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_i) && $past(rst_n)) |-> !tbe_o);

   assert_tsc_fall_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tsc_o) |-> $past(load_i));

   assert_irq_follows_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (($past(irq_sel_i) == IRQ_ON_DONE) ? $rose(tsc_o) : $rose(tbe_o)));

endmodule

// File: rtl/bufd_uart_tx.sv
module bufd_uart_tx
   import bufd_uart_tx_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter int OVERSAMPLE = 16,
   parameter int DATA_MAX   = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    div_val,
   input  logic                cfg_data8,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic                cfg_stop2,
   input  logic                cfg_irq_sel,
   input  logic                wr_en,
   input  logic [DATA_MAX-1:0] wr_data,
   output logic                txd,
   output logic                tbe,
   output logic                tsc,
   output logic                tx_irq
);

   generate
      if (DATA_MAX < 2) begin : g_bad_data
         $error("DATA_MAX must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (OVERSAMPLE < 1) begin : g_bad_os
         $error("OVERSAMPLE must be at least 1");
      end
   endgenerate

   frame_cfg_t          cfg;
   logic [DATA_MAX-1:0] hold_q;
   logic                bit_stb, slot_free, done, load;

   assign cfg = '{data8: cfg_data8, par_en: cfg_par_en,
                  par_odd: cfg_par_odd, stop2: cfg_stop2};

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else if (wr_en)
         hold_q <= wr_data;
   end

   assign load = bit_stb && slot_free && !tbe;

   bufd_uart_tx_baud #(
      .DIV_W      (DIV_W),
      .OVERSAMPLE (OVERSAMPLE)
   ) u_baud (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_val   (div_val),
      .bit_stb_o (bit_stb)
   );

   bufd_uart_tx_shifter #(
      .DATA_MAX   (DATA_MAX),
      .HAS_PARITY (HAS_PARITY)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_stb_i   (bit_stb),
      .load_i      (load),
      .data_i      (hold_q),
      .cfg_i       (cfg),
      .txd_o       (txd),
      .slot_free_o (slot_free),
      .done_o      (done)
   );

   bufd_uart_tx_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_en),
      .load_i    (load),
      .done_i    (done),
      .irq_sel_i (irq_src_e'(cfg_irq_sel)),
      .tbe_o     (tbe),
      .tsc_o     (tsc),
      .irq_o     (tx_irq)
   );

   assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tsc |-> txd);

   assert_done_only_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tsc) |-> $past(tbe));

endmodule

// File: tb/test_bufd_uart_tx.sv
module test_bufd_uart_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_val = 8'd1;
   logic       cfg_data8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic       cfg_stop2 = 1'b0, cfg_irq_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd, tbe, tsc, tx_irq;

   int checks = 0, fails = 0;
   int cyc = 0;
   int irq_cnt = 0;
   logic [7:0] exp_q[$];
   int start_cyc[$];
   bit done_flag = 0;

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   bufd_uart_tx i_bufd_uart_tx (
      .clk(clk), .rst_n(rst_n), .div_val(div_val),
      .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop2(cfg_stop2), .cfg_irq_sel(cfg_irq_sel),
      .wr_en(wr_en), .wr_data(wr_data),
      .txd(txd), .tbe(tbe), .tsc(tsc), .tx_irq(tx_irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int bit_len();
      return 16 * (int'(div_val) + 1);
   endfunction

   function automatic int frame_len();
      return 2 + (cfg_data8 ? 8 : 7) + (cfg_par_en ? 1 : 0) + (cfg_stop2 ? 1 : 0);
   endfunction

   function automatic logic [7:0] mask_data(input logic [7:0] d);
      return cfg_data8 ? d : (d & 8'h7F);
   endfunction

   function automatic logic exp_par(input logic [7:0] d);
      return (^mask_data(d)) ^ cfg_par_odd;
   endfunction

   always @(negedge clk) if (rst_n && tx_irq) irq_cnt++;

   // line monitor: decodes frames and compares with the expected queue
   logic [7:0] rx_d;
   logic [7:0] rx_e;
   logic       rx_p;
   int         rx_b;
   initial begin
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (txd === 1'b0) begin
            start_cyc.push_back(cyc);
            rx_b = bit_len();
            repeat (rx_b / 2) @(negedge clk);
            chk(txd === 1'b0, "R2", "start bit mid", int'(txd), 0);
            rx_d = 8'h00;
            for (int i = 0; i < (cfg_data8 ? 8 : 7); i++) begin
               repeat (rx_b) @(negedge clk);
               rx_d[i] = txd;
            end
            if (exp_q.size() > 0) rx_e = exp_q.pop_front();
            else begin
               rx_e = 8'hxx;
               chk(1'b0, "R11", "unexpected frame", int'(rx_d), -1);
            end
            chk(rx_d === mask_data(rx_e), "R2", "data bits", int'(rx_d), int'(mask_data(rx_e)));
            if (cfg_par_en) begin
               repeat (rx_b) @(negedge clk);
               rx_p = txd;
               chk(rx_p === exp_par(rx_e), "R3", "parity bit", int'(rx_p), int'(exp_par(rx_e)));
            end
            for (int s = 0; s < (cfg_stop2 ? 2 : 1); s++) begin
               repeat (rx_b) @(negedge clk);
               chk(txd === 1'b1, "R4", "stop bit", int'(txd), 1);
            end
         end
      end
   end

   task automatic write_char(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // send n characters gated by tbe; fixed >= 0 forces the value
   task automatic burst(input int n, input int fixed);
      int base, d, b, l, tr;
      logic [7:0] v;
      b = bit_len();
      l = frame_len();
      base = start_cyc.size();
      irq_cnt = 0;
      for (int k = 0; k < n; k++) begin
         while (tbe !== 1'b1) @(negedge clk);
         if (k > 0) chk(tsc === 1'b0, "R8", "tsc low while chaining", int'(tsc), 0);
         v = (fixed >= 0) ? 8'(fixed) : 8'($urandom);
         exp_q.push_back(v);
         write_char(v);
         chk(tbe === 1'b0, "R5", "tbe after write", int'(tbe), 0);
         if (k == 0) begin
            d = 1;
            while (tsc === 1'b1 && d < 4 * b) begin
               @(negedge clk);
               d++;
            end
            chk(d >= 2 && d <= b + 1, "R6", "tsc fall delay", d, b);
            chk(tbe === 1'b1, "R5", "tbe after load", int'(tbe), 1);
         end
      end
      while (tsc !== 1'b1) @(negedge clk);
      tr = cyc;
      repeat (3) @(negedge clk);
      chk(start_cyc.size() == base + n, "R11", "frames started", start_cyc.size() - base, n);
      for (int j = 1; j < n; j++)
         chk(start_cyc[base + j] - start_cyc[base + j - 1] == l * b, "R7",
             "frame spacing", start_cyc[base + j] - start_cyc[base + j - 1], l * b);
      if (start_cyc.size() > 0)
         chk(tr - start_cyc[start_cyc.size() - 1] == l * b, "R8", "tsc rise time",
             tr - start_cyc[start_cyc.size() - 1], l * b);
      chk(irq_cnt == (cfg_irq_sel ? 1 : n), "R9", "irq pulses", irq_cnt, cfg_irq_sel ? 1 : n);
      chk(exp_q.size() == 0, "R11", "queue drained", exp_q.size(), 0);
   endtask

   task automatic set_cfg(input int dv, input bit d8, input bit pe, input bit po,
                          input bit s2, input bit is);
      @(negedge clk);
      div_val = 8'(dv);
      cfg_data8 = d8; cfg_par_en = pe; cfg_par_odd = po;
      cfg_stop2 = s2; cfg_irq_sel = is;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
      chk(tbe === 1'b1, "R1", "tbe after reset", int'(tbe), 1);
      chk(tsc === 1'b1, "R1", "tsc after reset", int'(tsc), 1);
      chk(tx_irq === 1'b0, "R1", "irq after reset", int'(tx_irq), 0);

      // directed: 8N1, TBE interrupt
      set_cfg(1, 1, 0, 0, 0, 0);
      burst(3, -1);
      // directed: 7 bits, even parity, bit 7 must be ignored (R2, R3)
      set_cfg(0, 0, 1, 0, 0, 1);
      burst(2, 8'h80);
      // directed: 8 bits odd parity, two stop bits, TSC interrupt (R4)
      set_cfg(2, 1, 1, 1, 1, 1);
      burst(3, 8'h5A);

      // directed R10: overwrite of a waiting character
      set_cfg(0, 1, 0, 0, 0, 0);
      exp_q.push_back(8'hA5);
      write_char(8'hA5);
      while (tbe !== 1'b1) @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h11;
      @(negedge clk);
      wr_data = 8'h3C;
      @(negedge clk);
      wr_en = 1'b0;
      exp_q.push_back(8'h3C);
      while (tsc !== 1'b1) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R10", "replaced value sent", exp_q.size(), 0);
      chk(txd === 1'b1, "R8", "line idle", int'(txd), 1);

      // constrained random configurations
      for (int ph = 0; ph < 8; ph++) begin
         set_cfg($urandom_range(0, 2), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
         burst($urandom_range(2, 5), -1);
      end

      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule